// File: doc/BRIEF.md
# Single-Bit Asynchronous Static RAM Controller

This block lets a clocked host read and write an asynchronous static RAM that stores one bit per location and has separate data-in and data-out pins. The host presents a request with a read/write flag, a word address and one write bit while the controller shows it is idle. The controller then runs the memory strobes through a fixed sequence of phases, each timed by a parameter in clock cycles, and returns a one-cycle done pulse. On a read the pulse carries the bit sampled from the memory.

Every memory pin is driven from a register. The address and write bit are loaded on the accept edge, and the strobes move only on later edges. Chip select is pulled low only once the address is already on the pins. Write enable falls together with chip select, so the memory's output stays in high impedance for the whole write. Write enable is released one cycle before chip select. A recovery phase with both strobes high comes between accesses.

Top module: `bitram_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, the active-low chip select and write enable are high, `idle_o` is 1 and `rdy_o` is 0.
- R2: A request is taken only on an edge where `idle_o` is 1. `idle_o` is 0 in the cycle after that edge. A request made while `idle_o` is 0 changes no memory content, gives no done pulse and does not move the address pins.
- R3: A read (`wr_i`=0) drives the host address on the memory address pins, holds chip select low and write enable high, and raises `rdy_o` after the (ACC_CYC+1)-th clock edge following the accept edge. `rbit_o` then equals the bit stored at that address.
- R4: The read bit is sampled only after chip select has been low for ACC_CYC full cycles at an unchanged address.
- R5: A write (`wr_i`=1) pulls chip select and write enable low on the same edge. Both stay low for exactly WP_CYC cycles and write enable rises first. `rdy_o` rises after edge ARM+WP_CYC following the accept edge, where ARM = max(1, DS_CYC-WP_CYC).
- R6: The write bit is on the data pin from the accept edge onward, at least DS_CYC cycles before write enable rises, and it does not change while write enable is low.
- R7: The address pins change only on an accept edge and never while chip select is low.
- R8: Chip select rises at least one cycle after write enable. Both strobes are high while idle. `idle_o` returns REC_CYC clock edges after the edge that raised `rdy_o`.
- R9: `rdy_o` is a single-cycle pulse, given exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 1 | Host access request |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Host word address |
| wbit_i | input | 1 | Bit to write |
| idle_o | output | 1 | Controller can take a request |
| rdy_o | output | 1 | One-cycle done pulse |
| rbit_o | output | 1 | Bit read, valid with `rdy_o` on reads |
| sram_a_o | output | ADDR_W | Memory address pins |
| sram_cs_n_o | output | 1 | Memory chip select, active low |
| sram_we_n_o | output | 1 | Memory write enable, active low |
| sram_d_o | output | 1 | Memory data-in pin |
| sram_q_i | input | 1 | Memory data-out pin |

## Verification
The assertions assume the host raises `req_i` only while `idle_o` is high, or else that the request simply waits. They also assume reset is applied before any request. The bench keeps to this by waiting for `idle_o` before each directed access. It drives out-of-turn requests only in the one scenario that checks they are ignored, and it drops them before the controller returns to idle. The hand-written memory model returns the inverted bit until its access time has passed. It also counts address moves while selected and writes whose data was not set up in time, so a controller that breaks the pin timing gives wrong data or non-zero counts.

// File: rtl/bitram_pkg.sv
package bitram_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_FETCH,
        PH_ARM,
        PH_STROBE,
        PH_SETTLE
    } phase_e;

    typedef struct packed {
        logic load;
        logic sel_on;
        logic sel_off;
        logic wen_on;
        logic wen_off;
        logic capture;
        logic done;
    } pin_cmd_t;

    function automatic int unsigned arm_len(input int unsigned ds, input int unsigned wp);
        return (ds > wp) ? ds - wp : 1;
    endfunction

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/bitram_span.sv
module bitram_span #(
    parameter int unsigned CW = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] span_last,
    output logic [CW-1:0] count,
    output logic          at_end
);
    always_ff @(posedge clk) begin
        if (rst || restart) count <= '0;
        else                count <= count + 1'b1;
    end

    assign at_end = (count == span_last);
endmodule

// File: rtl/bitram_seq.sv
module bitram_seq
    import bitram_pkg::*;
#(
    parameter int unsigned ACC_CYC = 2,
    parameter int unsigned WP_CYC  = 2,
    parameter int unsigned DS_CYC  = 3,
    parameter int unsigned REC_CYC = 1
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     req_i,
    input  logic     wr_i,
    output phase_e   phase_o,
    output pin_cmd_t cmd_o
);
    localparam int unsigned FETCH_LEN = ACC_CYC + 1;
    localparam int unsigned ARM_LEN   = arm_len(DS_CYC, WP_CYC);
    localparam int unsigned LONGEST   = max4(FETCH_LEN, ARM_LEN, WP_CYC, REC_CYC);
    localparam int unsigned CW        = $clog2(LONGEST + 1);

    phase_e        phase, nxt;
    logic [CW-1:0] span_last;
    logic [CW-1:0] count;
    logic          at_end;
    logic          restart;

    always_comb begin
        unique case (phase)
            PH_FETCH:  span_last = CW'(FETCH_LEN - 1);
            PH_ARM:    span_last = CW'(ARM_LEN - 1);
            PH_STROBE: span_last = CW'(WP_CYC - 1);
            PH_SETTLE: span_last = CW'(REC_CYC - 1);
            default:   span_last = '0;
        endcase
    end

    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_IDLE:   if (req_i)  nxt = wr_i ? PH_ARM : PH_FETCH;
            PH_FETCH:  if (at_end) nxt = PH_SETTLE;
            PH_ARM:    if (at_end) nxt = PH_STROBE;
            PH_STROBE: if (at_end) nxt = PH_SETTLE;
            PH_SETTLE: if (at_end) nxt = PH_IDLE;
            default:               nxt = PH_IDLE;
        endcase
    end

    assign restart = (nxt != phase) || (phase == PH_IDLE);

    bitram_span #(.CW(CW)) u_span (
        .clk       (clk),
        .rst       (rst),
        .restart   (restart),
        .span_last (span_last),
        .count     (count),
        .at_end    (at_end)
    );

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= nxt;
    end

    always_comb begin
        cmd_o         = '0;
        cmd_o.load    = (phase == PH_IDLE) && req_i;
        cmd_o.sel_on  = ((phase == PH_FETCH) && (count == '0)) ||
                        ((phase == PH_ARM) && at_end);
        cmd_o.sel_off = ((phase == PH_FETCH) && at_end) || (phase == PH_SETTLE);
        cmd_o.wen_on  = (phase == PH_ARM) && at_end;
        cmd_o.wen_off = (phase == PH_STROBE) && at_end;
        cmd_o.capture = (phase == PH_FETCH) && at_end;
        cmd_o.done    = ((phase == PH_FETCH) || (phase == PH_STROBE)) && at_end;
    end

    assign phase_o = phase;
endmodule

// File: rtl/bitram_pins.sv
module bitram_pins
    import bitram_pkg::*;
#(
    parameter int unsigned AW = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  pin_cmd_t      cmd,
    input  logic [AW-1:0] addr_i,
    input  logic          wbit_i,
    input  logic          q_i,
    output logic [AW-1:0] a_o,
    output logic          cs_n_o,
    output logic          we_n_o,
    output logic          d_o,
    output logic          rdy_o,
    output logic          rbit_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            a_o    <= '0;
            d_o    <= 1'b0;
            cs_n_o <= 1'b1;
            we_n_o <= 1'b1;
            rdy_o  <= 1'b0;
            rbit_o <= 1'b0;
        end else begin
            if (cmd.load) begin
                a_o <= addr_i;
                d_o <= wbit_i;
            end
            if (cmd.sel_on)       cs_n_o <= 1'b0;
            else if (cmd.sel_off) cs_n_o <= 1'b1;
            if (cmd.wen_on)       we_n_o <= 1'b0;
            else if (cmd.wen_off) we_n_o <= 1'b1;
            if (cmd.capture)      rbit_o <= q_i;
            rdy_o <= cmd.done;
        end
    end
endmodule

// File: rtl/bitram_ctrl.sv
module bitram_ctrl
    import bitram_pkg::*;
#(
    parameter int unsigned ADDR_W  = 14,
    parameter int unsigned ACC_CYC = 2,
    parameter int unsigned WP_CYC  = 2,
    parameter int unsigned DS_CYC  = 3,
    parameter int unsigned REC_CYC = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wbit_i,
    output logic              idle_o,
    output logic              rdy_o,
    output logic              rbit_o,
    output logic [ADDR_W-1:0] sram_a_o,
    output logic              sram_cs_n_o,
    output logic              sram_we_n_o,
    output logic              sram_d_o,
    input  logic              sram_q_i
);
    phase_e   phase;
    pin_cmd_t cmd;

    bitram_seq #(
        .ACC_CYC (ACC_CYC),
        .WP_CYC  (WP_CYC),
        .DS_CYC  (DS_CYC),
        .REC_CYC (REC_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_i),
        .wr_i    (wr_i),
        .phase_o (phase),
        .cmd_o   (cmd)
    );

    bitram_pins #(.AW(ADDR_W)) u_pins (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .addr_i (addr_i),
        .wbit_i (wbit_i),
        .q_i    (sram_q_i),
        .a_o    (sram_a_o),
        .cs_n_o (sram_cs_n_o),
        .we_n_o (sram_we_n_o),
        .d_o    (sram_d_o),
        .rdy_o  (rdy_o),
        .rbit_o (rbit_o)
    );

    assign idle_o = (phase == PH_IDLE);
endmodule

// File: rtl/bitram_chk.sv
module bitram_chk #(
    parameter int unsigned ADDR_W = 14,
    parameter int unsigned WP_CYC = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_i,
    input logic              idle_o,
    input logic              rdy_o,
    input logic [ADDR_W-1:0] sram_a_o,
    input logic              sram_cs_n_o,
    input logic              sram_we_n_o,
    input logic              sram_d_o
);
    logic [15:0] we_run;

    always_ff @(posedge clk) begin
        if (rst)                 we_run <= '0;
        else if (sram_we_n_o)    we_run <= '0;
        else if (we_run != '1)   we_run <= we_run + 1'b1;
    end

    AST_TAKE_MOVES_ON: assert property (@(posedge clk) disable iff (rst)
        idle_o && req_i |=> !idle_o);                                   // R2
    AST_BUSY_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
        !idle_o |=> $stable(sram_a_o));                                 // R2
    AST_WEN_WITH_SEL: assert property (@(posedge clk) disable iff (rst)
        $fell(sram_we_n_o) |-> $fell(sram_cs_n_o));                     // R5
    AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n_o) |-> (we_run == 16'(WP_CYC)));                // R5
    AST_DIN_HELD: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n_o |-> $stable(sram_d_o));                            // R6
    AST_ADDR_WHILE_SEL: assert property (@(posedge clk) disable iff (rst)
        !sram_cs_n_o |-> $stable(sram_a_o));                            // R7
    AST_WEN_LIFTS_FIRST: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_cs_n_o) |-> $past(sram_we_n_o));                     // R8
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        idle_o |-> (sram_cs_n_o && sram_we_n_o));                       // R8
    AST_RDY_SINGLE: assert property (@(posedge clk) disable iff (rst)
        rdy_o |=> !rdy_o);                                              // R9
endmodule

bind bitram_ctrl bitram_chk #(
    .ADDR_W (ADDR_W),
    .WP_CYC (WP_CYC)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .req_i       (req_i),
    .idle_o      (idle_o),
    .rdy_o       (rdy_o),
    .sram_a_o    (sram_a_o),
    .sram_cs_n_o (sram_cs_n_o),
    .sram_we_n_o (sram_we_n_o),
    .sram_d_o    (sram_d_o)
);

// File: tb/sim_bitram_ctrl.sv
`timescale 1ns/1ps
module sim_bitram_ctrl;
    localparam int AW     = 14;
    localparam int DEPTH  = 1 << AW;
    localparam int ACC    = 3;
    localparam int WP     = 2;
    localparam int DS     = 5;
    localparam int REC    = 2;
    localparam int ARM    = (DS > WP) ? DS - WP : 1;
    localparam int RD_LAT = ACC + 1;
    localparam int WR_LAT = ARM + WP;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          wbit = 1'b0;
    logic          idle, rdy, rbit;
    logic [AW-1:0] sa;
    logic          cs_n, we_n, sd;
    logic          sq;

    int tests = 0;
    int fails = 0;
    int writes_issued = 0;

    always #2.5 clk = ~clk;

    bitram_ctrl #(
        .ADDR_W (AW), .ACC_CYC (ACC), .WP_CYC (WP), .DS_CYC (DS), .REC_CYC (REC)
    ) u0 (
        .clk (clk), .rst (rst), .req_i (req), .wr_i (wr), .addr_i (addr),
        .wbit_i (wbit), .idle_o (idle), .rdy_o (rdy), .rbit_o (rbit),
        .sram_a_o (sa), .sram_cs_n_o (cs_n), .sram_we_n_o (we_n),
        .sram_d_o (sd), .sram_q_i (sq)
    );

    // ---------------- behavioural memory device ----------------
    bit            dev_mem [DEPTH];
    logic          pv_cs_n = 1'b1;
    logic [AW-1:0] pv_a = '0;
    logic          pv_d = 1'b0;
    int            sel_age = 0;
    int            din_age = 0;
    logic          pend = 1'b0;
    logic [AW-1:0] pend_a = '0;
    logic          pend_d = 1'b0;
    int            pend_age = 0;
    int            addr_viol = 0;
    int            ds_viol = 0;
    int            commits = 0;

    always @(negedge clk) begin
        if (!cs_n && !pv_cs_n && sa != pv_a) addr_viol++;
        if (!cs_n) sel_age = (!pv_cs_n && sa == pv_a) ? sel_age + 1 : 1;
        else       sel_age = 0;
        din_age = (sd == pv_d) ? din_age + 1 : 1;
        if (!cs_n && !we_n) begin
            pend = 1'b1; pend_a = sa; pend_d = sd; pend_age = din_age;
        end else if (pend) begin
            dev_mem[pend_a] = pend_d;
            commits++;
            if (pend_age < DS) ds_viol++;
            pend = 1'b0;
        end
        pv_cs_n = cs_n; pv_a = sa; pv_d = sd;
    end

    always_comb begin
        if (!cs_n && we_n) sq = (sel_age >= ACC) ? dev_mem[sa] : ~dev_mem[sa];
        else               sq = 1'b0;
    end

    // ---------------- bench bookkeeping ----------------
    bit          exp_mem [DEPTH];
    logic [31:0] seed = 32'h1bad_c0de;

    function automatic logic [31:0] next_rand();
        seed = seed ^ (seed << 13);
        seed = seed ^ (seed >> 17);
        seed = seed ^ (seed << 5);
        return seed;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("[TB] FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    // One access; returns read bit, latency and idle-return gap
    task automatic access(input bit w, input logic [AW-1:0] a, input bit b,
                          output bit got, output int lat, output int back);
        while (!idle) @(negedge clk);
        req = 1'b1; wr = w; addr = a; wbit = b;
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        lat = 0;
        for (int i = 0; i < 60; i++) begin
            @(posedge clk); lat++;
            @(negedge clk);
            if (rdy) break;
        end
        got = rbit;
        back = 0;
        while (!idle && back < 60) begin
            @(negedge clk); back++;
        end
        if (w) begin
            writes_issued++;
            exp_mem[a] = b;
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input bit b);
        bit g; int lat; int back;
        access(1'b1, a, b, g, lat, back);
        chk(lat == WR_LAT, "R5 write latency", lat, WR_LAT);
        chk(back == REC, "R8 recovery after write", back, REC);
    endtask

    task automatic do_read(input logic [AW-1:0] a);
        bit g; int lat; int back;
        access(1'b0, a, 1'b0, g, lat, back);
        chk(lat == RD_LAT, "R3 read latency", lat, RD_LAT);
        chk(g == exp_mem[a], "R3 R4 read data", int'(g), int'(exp_mem[a]));
        chk(back == REC, "R8 recovery after read", back, REC);
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        @(negedge clk);
        chk(cs_n == 1'b1, "R1 select high in reset", cs_n, 1);
        chk(we_n == 1'b1, "R1 write enable high in reset", we_n, 1);
        chk(idle == 1'b1, "R1 idle in reset", idle, 1);
        chk(rdy == 1'b0, "R1 no done in reset", rdy, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(cs_n && we_n && idle && !rdy, "R1 state after reset", {cs_n, we_n, idle, rdy}, 4'b1110);
    endtask

    task automatic t_edges();
        do_write(14'h0000, 1'b1);
        do_write(14'h3fff, 1'b1);
        do_read(14'h0000);
        do_read(14'h3fff);
        do_write(14'h3fff, 1'b0);
        do_read(14'h3fff);
        do_read(14'h0000);
    endtask

    task automatic t_random_pairs();
        logic [AW-1:0] list [16];
        for (int i = 0; i < 16; i++) begin
            list[i] = AW'(next_rand());
            do_write(list[i], next_rand() >> 31);
        end
        for (int i = 15; i >= 0; i--) do_read(list[i]);
    endtask

    task automatic t_toggle_same();
        for (int i = 0; i < 4; i++) begin
            do_write(14'h1555, i[0]);
            do_read(14'h1555);
        end
    endtask

    task automatic t_busy_ignore();
        int pulses;
        int busy_seen;
        do_write(14'h0006, 1'b0);
        do_write(14'h0005, 1'b0);
        while (!idle) @(negedge clk);
        req = 1'b1; wr = 1'b1; addr = 14'h0005; wbit = 1'b1;
        @(posedge clk);
        @(negedge clk);
        writes_issued++;
        exp_mem[14'h0005] = 1'b1;
        addr = 14'h0006;
        pulses = 0;
        busy_seen = 0;
        for (int i = 0; i < 3; i++) begin
            if (!idle) busy_seen++;
            if (sa != 14'h0005) chk(1'b0, "R2 address moved while busy", int'(sa), 5);
            @(negedge clk);
            if (rdy) pulses++;
        end
        req = 1'b0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (rdy) pulses++;
        end
        chk(busy_seen == 3, "R2 idle low after accept", busy_seen, 3);
        chk(pulses == 1, "R9 one done pulse per access", pulses, 1);
        do_read(14'h0006);
        do_read(14'h0005);
    endtask

    task automatic t_pin_audit();
        chk(addr_viol == 0, "R7 address moved while selected", addr_viol, 0);
        chk(ds_viol == 0, "R6 data setup too short", ds_viol, 0);
        chk(commits == writes_issued, "R5 R9 write strobes per request", commits, writes_issued);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("[TB] FAIL R9 watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_edges();
        t_random_pairs();
        t_toggle_same();
        t_busy_ignore();
        repeat (4) @(negedge clk);
        t_pin_audit();
        finish_run();
    end
endmodule